// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is a small SPI master that a CPU drives through two registers on a simple register bus. The control register holds these settings: the serial clock rate, which of three peripherals is selected, an 8-bit or 16-bit word size, whether the select stays asserted after a word, an interrupt enable and a bus enable. The control register also reports a busy flag. A write to the data register starts a shift. When busy clears, a read of the same register returns the word that came back from the peripheral.

Serial transfers use SPI mode 0. The clock idles low, the most significant bit goes first, MISO is sampled on the rising edge of SCK and MOSI changes on the falling edge. The serial clock comes from the system clock through a divider of 2×DIV_N, 4×DIV_N, 8×DIV_N or 16×DIV_N. Software can keep the chip select asserted across several words, so a peripheral can receive a multi-byte command.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset the control register reads 0x0000, all three selects are high, SCK is low and the interrupt output is low.
- R2: Control bits 1:0 set the rate. Each SCK high phase and each SCK low phase lasts DIV_N×2^code system clocks, so code 0 is the fastest rate and each higher code halves it.
- R3: Control bit 7 is read-only. It reads 1 from the cycle after a transfer starts until the last bit has shifted, and reads 0 otherwise.
- R4: Control bits 9:8 pick a device. Value d (0, 1 or 2) drives select output d low while that device is selected. Value 3 drives no select low. At most one select is ever low.
- R5: Control bit 10 picks the word size: 0 gives 8-bit words and 1 gives 16-bit words. In 8-bit mode the data register uses bits 7:0 and reads back with bits 15:8 at zero.
- R6: Control bit 11 = 0 releases the select when the word ends. Control bit 11 = 1 keeps the select low after the word ends, until a later word ends with the bit at 0 or the bus is disabled.
- R7: When control bit 14 is 1, the interrupt output pulses high for exactly one clock at the end of each word. When bit 14 is 0, the interrupt output stays low.
- R8: While control bit 15 is 0, a data write starts nothing, SCK does not toggle and every select stays high.
- R9: Control bits 13:12 and 6:2 always read 0. Bits 15, 14, 11, 10, 9:8 and 1:0 read back the value last written.
- R10: A data write while busy is ignored. The word in flight, its MOSI bits and its clock count are unchanged.
- R11: Words shift MSB first in SPI mode 0. MOSI changes on falling SCK, MISO is sampled on rising SCK, and the data register returns the received word once busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register select: 0 = control, 1 = data |
| busWr | input | 1 | Write strobe for the selected register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the selected register (combinational) |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the peripheral |
| spiMiso | input | 1 | Serial data from the peripheral |
| spiCsN | output | 3 | Active-low selects, one per device |
| irq | output | 1 | One-clock end-of-word interrupt pulse |

## Verification
The bench models an SPI slave that returns a known word. It checks both directions at the slowest and the fastest rate, and in 8-bit and 16-bit sizes. A design that swapped the sampling edges, or that misaligned 8-bit words in the shifter, would return a shifted or garbled word. The bench measures the SCK high time at two rate codes, which catches a divider scaled the wrong way. It also writes the data register in the middle of a word: a design that restarted on that write would show extra clock edges or altered MOSI bits. Finally it checks select hold across two words, device value 3 and the disabled bus. A design that got these wrong would drop the select early, drive a stray select, or start shifting while disabled.

// File: rtl/spi_legacy_pkg.sv
package spi_legacy_pkg;
  // strobes from the control side to the shift datapath
  typedef struct packed {
    logic        start;
    logic        wide;
    logic [1:0]  rate;
    logic [15:0] txData;
  } spi_strobe_t;
endpackage

// File: rtl/spi_legacy_dp.sv
module spi_legacy_dp
  import spi_legacy_pkg::*;
#(
  parameter int DIV_N = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  spi_strobe_t strb,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        active,
  output logic        done,
  output logic [15:0] rxWord
);
  localparam int CNT_W = $clog2(DIV_N * 8 + 1);

  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfLimit;
  logic [1:0]       rateQ;
  logic             wideQ;
  logic [4:0]       bitsLeft;
  logic             rxBit;
  logic [15:0]      shiftQ;
  logic             tick;

  always_comb begin
    halfLimit = CNT_W'(DIV_N) << rateQ;
    tick      = active && (halfCnt == halfLimit - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      done     <= 1'b0;
      sck      <= 1'b0;
      halfCnt  <= '0;
      rateQ    <= 2'd0;
      wideQ    <= 1'b0;
      bitsLeft <= 5'd0;
      rxBit    <= 1'b0;
      shiftQ   <= 16'h0000;
    end else begin
      done <= 1'b0;
      if (strb.start && !active) begin
        active   <= 1'b1;
        sck      <= 1'b0;
        halfCnt  <= '0;
        rateQ    <= strb.rate;
        wideQ    <= strb.wide;
        bitsLeft <= strb.wide ? 5'd16 : 5'd8;
        shiftQ   <= strb.wide ? strb.txData : {strb.txData[7:0], 8'h00};
      end else if (active) begin
        if (tick) begin
          halfCnt <= '0;
          sck     <= ~sck;
          if (!sck) begin
            rxBit <= miso;                       // rising edge: sample
          end else begin
            shiftQ   <= {shiftQ[14:0], rxBit};   // falling edge: shift
            bitsLeft <= bitsLeft - 5'd1;
            if (bitsLeft == 5'd1) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + CNT_W'(1);
        end
      end
    end
  end

  assign mosi   = shiftQ[15];
  assign rxWord = wideQ ? shiftQ : {8'h00, shiftQ[7:0]};

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> active);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> !active);
  assert_sck_idles_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> !sck);
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(active));
endmodule

// File: rtl/spi_legacy_ctrl.sv
module spi_legacy_ctrl
  import spi_legacy_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic              active,
  input  logic              done,
  input  logic [15:0]       rxWord,
  output spi_strobe_t       strb,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);
  logic       busEn;
  logic       irqEn;
  logic       csHold;
  logic       wide;
  logic [1:0] dev;
  logic [1:0] rate;
  logic       csActive;
  logic       startReq;

  assign startReq     = busWr && busSel && busEn && !active;
  assign strb.start   = startReq;
  assign strb.wide    = wide;
  assign strb.rate    = rate;
  assign strb.txData  = busWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busEn    <= 1'b0;
      irqEn    <= 1'b0;
      csHold   <= 1'b0;
      wide     <= 1'b0;
      dev      <= 2'd0;
      rate     <= 2'd0;
      csActive <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= done && irqEn;
      if (busWr && !busSel) begin
        busEn  <= busWrData[15];
        irqEn  <= busWrData[14];
        csHold <= busWrData[11];
        wide   <= busWrData[10];
        dev    <= busWrData[9:8];
        rate   <= busWrData[1:0];
      end
      if (done && !csHold) csActive <= 1'b0;
      if (startReq)        csActive <= 1'b1;
      if (!busEn || (busWr && !busSel && !busWrData[15])) csActive <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(busEn && csActive && (dev == 2'(g)));
  end

  assign busRdData = busSel ? rxWord
                   : {busEn, irqEn, 2'b00, csHold, wide, dev, active, 5'b00000, rate};

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busEn && !active) |=> !active);
  assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(done) && $past(irqEn)));
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

// File: rtl/spi_legacy_master.sv
module spi_legacy_master
  import spi_legacy_pkg::*;
#(
  parameter int DIV_N = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic [2:0]  spiCsN,
  output logic        irq
);
  spi_strobe_t strb;
  logic        active;
  logic        done;
  logic [15:0] rxWord;

  spi_legacy_ctrl #(.NUM_CS(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .active(active),
    .done(done), .rxWord(rxWord), .strb(strb), .csN(spiCsN), .irq(irq)
  );

  spi_legacy_dp #(.DIV_N(DIV_N)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(spiMiso), .sck(spiSck),
    .mosi(spiMosi), .active(active), .done(done), .rxWord(rxWord)
  );
endmodule

// File: tb/spi_legacy_master_tb_top.sv
module spi_legacy_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_N = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWrData = 16'h0;
  logic [15:0] busRdData;
  logic        spiSck;
  logic        spiMosi;
  logic        spiMiso;
  logic [2:0]  spiCsN;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] slaveTx = 16'h0;
  logic [15:0] mosiSeen = 16'h0;
  int riseCnt = 0;
  int irqCnt = 0;
  time tRise = 0;
  time highWidth = 0;

  logic [31:0] expQ[$];
  logic [31:0] actQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_legacy_master #(.DIV_N(DIV_N)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN), .irq(irq)
  );

  // slave model
  assign spiMiso = slaveTx[15];
  always @(posedge spiSck) begin
    mosiSeen = {mosiSeen[14:0], spiMosi};
    riseCnt++;
    tRise = $time;
  end
  always @(negedge spiSck) begin
    slaveTx = {slaveTx[14:0], 1'b0};
    highWidth = $time - tRise;
  end
  always @(posedge clk) if (irq) irqCnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [15:0] d);
    @(negedge clk);
    busSel = sel;
    #1 d = busRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int i = 0; i < 5000; i++) begin
      busRead(1'b0, v);
      if (!v[7]) break;
    end
  endtask

  // driver: pushes expected {rx, mosi} into the scoreboard
  task automatic doXfer(input logic [15:0] ctrl, input logic [15:0] tx,
                        input logic [15:0] slave, input logic [2:0] expCs,
                        input bit poke);
    logic [15:0] v;
    logic [15:0] rx;
    bit w;
    w = ctrl[10];
    busWrite(1'b0, ctrl);
    slaveTx = w ? slave : {slave[7:0], 8'h00};
    mosiSeen = 16'h0; riseCnt = 0; irqCnt = 0;
    expQ.push_back({(w ? slave : {8'h00, slave[7:0]}), (w ? tx : {8'h00, tx[7:0]})});
    busWrite(1'b1, tx);
    busRead(1'b0, v);
    check(v[7] == 1'b1, "R3 busy during word", v[7], 1);
    check(spiCsN == expCs, "R4 select during word", spiCsN, expCs);
    if (poke) busWrite(1'b1, 16'h0F0F);
    waitIdle();
    busRead(1'b0, v);
    check(v[7] == 1'b0, "R3 busy clear", v[7], 0);
    busRead(1'b1, rx);
    actQ.push_back({rx, (w ? mosiSeen : {8'h00, mosiSeen[7:0]})});
  endtask

  // monitor: compares results against the expected queue
  initial begin
    forever begin
      wait (actQ.size() != 0);
      begin
        logic [31:0] e;
        logic [31:0] a;
        e = expQ.pop_front();
        a = actQ.pop_front();
        check(a[31:16] == e[31:16], "R11/R5 received word", a[31:16], e[31:16]);
        check(a[15:0] == e[15:0], "R11/R5 MOSI word", a[15:0], e[15:0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead(1'b0, v);
    check(v == 16'h0000, "R1 control reset", v, 0);
    check(spiCsN == 3'b111 && spiSck == 1'b0 && irq == 1'b0, "R1 pins reset",
          {spiCsN, spiSck, irq}, 5'b11100);
    // R9 readback with reserved bits zero
    busWrite(1'b0, 16'hFFFF);
    busRead(1'b0, v);
    check(v == 16'hCF03, "R9 control readback", v, 16'hCF03);
    busWrite(1'b0, 16'h0000);
    // R8 disabled bus ignores data write
    riseCnt = 0;
    busWrite(1'b1, 16'h00A5);
    repeat (50) @(negedge clk);
    busRead(1'b0, v);
    check(v[7] == 1'b0, "R8 no start while disabled", v[7], 0);
    check(riseCnt == 0 && spiCsN == 3'b111, "R8 pins idle while disabled",
          {riseCnt[3:0], spiCsN}, 7'b0000111);
    // basic 8-bit, device 0, fastest rate
    doXfer(16'h8000, 16'h00A5, 16'h003C, 3'b110, 0);
    check(highWidth == DIV_N * CLK_PERIOD, "R2 rate code 0 high time", int'(highWidth), DIV_N * CLK_PERIOD);
    check(spiCsN == 3'b111, "R6 select released", spiCsN, 3'b111);
    check(irqCnt == 0, "R7 no irq when disabled", irqCnt, 0);
    // R5 16-bit, device 1, rate 1
    doXfer(16'h8501, 16'h1234, 16'hBEEF, 3'b101, 0);
    check(riseCnt == 16, "R5 16 clocks per wide word", riseCnt, 16);
    // R2 slowest rate, device 2
    doXfer(16'h8203, 16'h005A, 16'h00C3, 3'b011, 0);
    check(highWidth == DIV_N * 8 * CLK_PERIOD, "R2 rate code 3 high time", int'(highWidth), DIV_N * 8 * CLK_PERIOD);
    // R6 hold across two words
    doXfer(16'h8A00, 16'h0001, 16'h0080, 3'b011, 0);
    check(spiCsN == 3'b011, "R6 select held after word", spiCsN, 3'b011);
    doXfer(16'h8200, 16'h0002, 16'h0040, 3'b011, 0);
    check(spiCsN == 3'b111, "R6 select released after unheld word", spiCsN, 3'b111);
    // R7 interrupt pulse
    doXfer(16'hC000, 16'h0077, 16'h0011, 3'b110, 0);
    check(irqCnt == 1, "R7 one irq pulse", irqCnt, 1);
    // R10 write while busy ignored
    doXfer(16'h8001, 16'h0096, 16'h0069, 3'b110, 1);
    check(riseCnt == 8, "R10 clock count unchanged", riseCnt, 8);
    // R4 device 3 selects nothing
    doXfer(16'h8300, 16'h00FF, 16'h0000, 3'b111, 0);
    wait (actQ.size() == 0);
    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule